// File: doc/BRIEF.md
# Control port decoder with bank and boot-override latches

This block sits on the 8-bit I/O side of a small processor card. It watches the port address, the write data and the I/O read and write strobes. When an access falls inside its group of six ports, it raises a one-cycle select strobe for the matching register of an external counter/timer. It also keeps two single-bit control latches of its own.

The first latch drives a memory-bank extension line that chooses between two memory banks sitting at the same addresses. The second is a boot override, armed by reset. While it is armed, the four top address lines are forced high, so the processor can only reach the top 4 KB of its space and starts from a boot ROM there. Software releases the override once RAM below it has been loaded.

A static configuration input moves the whole group from its default base to an alternate base. The counter/timer, its interrupt registers and the bus drivers are outside this block.

Top module: `ctl_port_dec`

## Requirements
- R1: With `alt_base_i`=0 the group is ports F0 to F5. Offsets 0, 1 and 2 select counter channels 0, 1 and 2: a read pulses `chan_rd_o[n]` and a write pulses `chan_wr_o[n]`.
- R2: With `alt_base_i`=1 the same offsets map to ports E8 to ED, and the default ports F0 to F5 are no longer decoded.
- R3: A write to offset 3 pulses `mode_wr_o`. A write to offset 4 pulses `ctl_wr_o`. A read of offset 4 pulses `stat_rd_o`.
- R4: An access to any port outside the selected group raises no strobe and changes neither latch.
- R5: Each qualified access gives exactly one strobe cycle. The strobe is visible in the clock cycle after the first rising clock edge at which the I/O strobe is sampled high. Holding the I/O strobe high for longer gives no further pulse.
- R6: A write to offset 5 loads write-data bit 0 into `bank_o`. Reset clears `bank_o` to 0.
- R7: After reset `addr_force_o` is 4'hF.
- R8: A write to offset 4 with data bit 0 = 1 drives `addr_force_o` to 0 from the same cycle as the strobe. Such a write with bit 0 = 0 leaves the override unchanged.
- R9: Once released, the override stays released until the next reset. Later writes to offset 4 do not re-arm it.
- R10: A read of offset 3 or offset 5 pulses `unused_rd_o` with `rd_data_o`=8'hFF. In every other cycle `rd_data_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_base_i | input | 1 | Static base select: 0 = F0 group, 1 = E8 group |
| io_addr_i | input | 8 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rd_i | input | 1 | I/O read strobe, active high |
| io_wr_i | input | 1 | I/O write strobe, active high |
| chan_rd_o | output | 3 | Counter channel data read selects |
| chan_wr_o | output | 3 | Counter channel data write selects |
| mode_wr_o | output | 1 | Counter mode register write select |
| ctl_wr_o | output | 1 | Control port write select (offset 4) |
| stat_rd_o | output | 1 | Status port read select (offset 4) |
| unused_rd_o | output | 1 | Read of an unused offset |
| rd_data_o | output | 8 | Read data for unused offsets |
| bank_o | output | 1 | Memory-bank extension line |
| addr_force_o | output | 4 | Forced-high upper address bits |

## Verification
The bench holds every I/O strobe for two cycles. A decoder that reacts to the level of the strobe rather than its edge would therefore show a second pulse, or a pulse two cycles long.

It writes to the release port with bit 0 clear before the real release, then writes zero again after the release. A design that reloads the override from the data bit would drop the forced lines too early or raise them again.

It probes the ports on both sides of each group boundary, E7, EE, EF and F6, and changes the base while idle. An off-by-one range check or a fixed base would select the wrong register there.

It reads offsets 3 and 5, where a design that mixes up read and write decoding would raise a mode or bank strobe instead of returning 0xFF.

// File: rtl/ctl_port_dec_pkg.sv
package ctl_port_dec_pkg;
  // Offsets inside the six-port group; the order is fixed by the card map.
  localparam int unsigned OFF_CH0  = 0;
  localparam int unsigned OFF_MODE = 3;
  localparam int unsigned OFF_CTL  = 4;
  localparam int unsigned OFF_BANK = 5;
  localparam logic [7:0]  UNUSED_RD_VAL = 8'hFF;

  typedef struct packed {
    logic mode_wr;
    logic ctl_wr;
    logic stat_rd;
    logic unused_rd;
  } misc_sel_t;
endpackage

// File: rtl/io_rise_det.sv
module io_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_i,
  output logic rise_o
);
  logic strb_q;
  logic strb_d;

  always_comb strb_d = strb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strb_d;
  end

  assign rise_o = strb_i & ~strb_q;
endmodule

// File: rtl/port_range_dec.sv
module port_range_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_PORTS = 6,
  parameter logic [ADDR_W-1:0] BASE_DFLT = 8'hF0,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 8'hE8,
  localparam int unsigned OFF_W = $clog2(NUM_PORTS)
) (
  input  logic              alt_base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [ADDR_W-1:0] NP = ADDR_W'(NUM_PORTS);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    base  = alt_base_i ? BASE_ALT : BASE_DFLT;
    diff  = addr_i - base;
    hit_o = (diff < NP);
    off_o = diff[OFF_W-1:0];
  end
endmodule

// File: rtl/ctl_bit_latches.sv
module ctl_bit_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic bank_we_i,
  input  logic boot_we_i,
  input  logic bit_i,
  output logic bank_o,
  output logic armed_o
);
  logic bank_q, bank_d;
  logic armed_q, armed_d;

  always_comb begin
    bank_d  = bank_we_i ? bit_i : bank_q;
    // Release only; a later zero never re-arms.
    armed_d = (boot_we_i && bit_i) ? 1'b0 : armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      bank_q  <= bank_d;
      armed_q <= armed_d;
    end
  end

  assign bank_o  = bank_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/ctl_port_dec.sv
module ctl_port_dec
  import ctl_port_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned FORCE_W   = 4,
  parameter logic [ADDR_W-1:0] BASE_DFLT = 8'hF0,
  parameter logic [ADDR_W-1:0] BASE_ALT  = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_base_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  output logic [NUM_CH-1:0] chan_rd_o,
  output logic [NUM_CH-1:0] chan_wr_o,
  output logic              mode_wr_o,
  output logic              ctl_wr_o,
  output logic              stat_rd_o,
  output logic              unused_rd_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              bank_o,
  output logic [FORCE_W-1:0] addr_force_o
);
  localparam int unsigned OFF_W = $clog2(NUM_PORTS);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             wr_rise, rd_rise;
  logic             hit;
  logic [OFF_W-1:0] off;

  io_rise_det u_wr_edge (.clk(clk), .rst_n(rst_int_n), .strb_i(io_wr_i), .rise_o(wr_rise));
  io_rise_det u_rd_edge (.clk(clk), .rst_n(rst_int_n), .strb_i(io_rd_i), .rise_o(rd_rise));

  port_range_dec #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS),
    .BASE_DFLT(BASE_DFLT), .BASE_ALT(BASE_ALT)
  ) u_dec (
    .alt_base_i(alt_base_i), .addr_i(io_addr_i), .hit_o(hit), .off_o(off)
  );

  logic wr_acc, rd_acc;
  assign wr_acc = wr_rise & hit;
  assign rd_acc = rd_rise & hit;

  // Next-state select strobes.
  logic [NUM_CH-1:0] chan_wr_d, chan_rd_d;
  logic [NUM_CH-1:0] chan_wr_q, chan_rd_q;
  misc_sel_t         misc_d, misc_q;
  logic [DATA_W-1:0] rdat_d, rdat_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    localparam logic [OFF_W-1:0] CH_OFF = OFF_W'(OFF_CH0 + k);
    assign chan_wr_d[k] = wr_acc && (off == CH_OFF);
    assign chan_rd_d[k] = rd_acc && (off == CH_OFF);
  end

  always_comb begin
    misc_d.mode_wr   = wr_acc && (off == OFF_W'(OFF_MODE));
    misc_d.ctl_wr    = wr_acc && (off == OFF_W'(OFF_CTL));
    misc_d.stat_rd   = rd_acc && (off == OFF_W'(OFF_CTL));
    misc_d.unused_rd = rd_acc && ((off == OFF_W'(OFF_MODE)) || (off == OFF_W'(OFF_BANK)));
    rdat_d           = misc_d.unused_rd ? DATA_W'(UNUSED_RD_VAL) : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chan_wr_q <= '0;
      chan_rd_q <= '0;
      misc_q    <= '0;
      rdat_q    <= '0;
    end else begin
      chan_wr_q <= chan_wr_d;
      chan_rd_q <= chan_rd_d;
      misc_q    <= misc_d;
      rdat_q    <= rdat_d;
    end
  end

  logic bank_we, boot_we, armed;
  assign bank_we = wr_acc && (off == OFF_W'(OFF_BANK));
  assign boot_we = misc_d.ctl_wr;

  ctl_bit_latches u_latch (
    .clk(clk), .rst_n(rst_int_n),
    .bank_we_i(bank_we), .boot_we_i(boot_we), .bit_i(io_wdata_i[0]),
    .bank_o(bank_o), .armed_o(armed)
  );

  assign chan_wr_o    = chan_wr_q;
  assign chan_rd_o    = chan_rd_q;
  assign mode_wr_o    = misc_q.mode_wr;
  assign ctl_wr_o     = misc_q.ctl_wr;
  assign stat_rd_o    = misc_q.stat_rd;
  assign unused_rd_o  = misc_q.unused_rd;
  assign rd_data_o    = rdat_q;
  assign addr_force_o = {FORCE_W{armed}};
endmodule

// File: rtl/ctl_port_dec_chk.sv
module ctl_port_dec_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned FORCE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic              io_rd_i,
  input logic              io_wr_i,
  input logic [NUM_CH-1:0] chan_rd_o,
  input logic [NUM_CH-1:0] chan_wr_o,
  input logic              mode_wr_o,
  input logic              ctl_wr_o,
  input logic              stat_rd_o,
  input logic              unused_rd_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              bank_o,
  input logic [FORCE_W-1:0] addr_force_o
);
  logic any_wr, any_rd;
  assign any_wr = (|chan_wr_o) | mode_wr_o | ctl_wr_o;
  assign any_rd = (|chan_rd_o) | stat_rd_o | unused_rd_o;

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> !any_wr);
  assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_rd |=> !any_rd);
  assert_wr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> $past(io_wr_i));
  assert_rd_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_rd |-> $past(io_rd_i));
  assert_wr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_wr_o, mode_wr_o, ctl_wr_o}));
  assert_rd_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_rd_o, stat_rd_o, unused_rd_o}));
  assert_bank_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_o) |-> $past(io_wr_i));
  assert_force_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (addr_force_o == '1));
  assert_release_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_force_o[0]) |-> (ctl_wr_o && $past(io_wdata_i[0])));
  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_force_o == '0) |=> (addr_force_o == '0));
  assert_unused_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unused_rd_o |-> (rd_data_o == 8'hFF));
  assert_idle_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !unused_rd_o |-> (rd_data_o == '0));
endmodule

bind ctl_port_dec ctl_port_dec_chk #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .FORCE_W(FORCE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_wdata_i(io_wdata_i),
  .io_rd_i(io_rd_i), .io_wr_i(io_wr_i),
  .chan_rd_o(chan_rd_o), .chan_wr_o(chan_wr_o),
  .mode_wr_o(mode_wr_o), .ctl_wr_o(ctl_wr_o), .stat_rd_o(stat_rd_o),
  .unused_rd_o(unused_rd_o), .rd_data_o(rd_data_o),
  .bank_o(bank_o), .addr_force_o(addr_force_o)
);

// File: tb/ctl_port_dec_tb_top.sv
`timescale 1ns/1ps
module ctl_port_dec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alt_base_i = 1'b0;
  logic [7:0] io_addr_i = '0;
  logic [7:0] io_wdata_i = '0;
  logic       io_rd_i = 1'b0;
  logic       io_wr_i = 1'b0;
  logic [2:0] chan_rd_o, chan_wr_o;
  logic       mode_wr_o, ctl_wr_o, stat_rd_o, unused_rd_o, bank_o;
  logic [7:0] rd_data_o;
  logic [3:0] addr_force_o;

  always #2.5 clk = ~clk;

  ctl_port_dec dut_i (
    .clk(clk), .rst_n(rst_n), .alt_base_i(alt_base_i),
    .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i),
    .io_rd_i(io_rd_i), .io_wr_i(io_wr_i),
    .chan_rd_o(chan_rd_o), .chan_wr_o(chan_wr_o),
    .mode_wr_o(mode_wr_o), .ctl_wr_o(ctl_wr_o), .stat_rd_o(stat_rd_o),
    .unused_rd_o(unused_rd_o), .rd_data_o(rd_data_o),
    .bank_o(bank_o), .addr_force_o(addr_force_o)
  );

  typedef struct packed {
    logic [2:0] crd, cwr;
    logic       mwr, cw, srd, urd;
    logic [7:0] rdat;
    logic       bank;
    logic [3:0] force_v;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0, n_fail = 0;
  logic  m_bank = 1'b0, m_armed = 1'b1;

  function automatic obs_t sample();
    obs_t o;
    o = '{crd: chan_rd_o, cwr: chan_wr_o, mwr: mode_wr_o, cw: ctl_wr_o,
          srd: stat_rd_o, urd: unused_rd_o, rdat: rd_data_o,
          bank: bank_o, force_v: addr_force_o};
    return o;
  endfunction

  function automatic obs_t idle_exp();
    obs_t o;
    o = '0;
    o.bank = m_bank;
    o.force_v = {4{m_armed}};
    return o;
  endfunction

  // Monitor: pops one expected item per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      obs_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = sample();
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic access(input bit is_wr, input logic [7:0] addr,
                        input logic [7:0] data, input string tag);
    obs_t e;
    logic [7:0] base, off;
    bit hit;
    @(negedge clk);
    io_addr_i = addr; io_wdata_i = data;
    if (is_wr) io_wr_i = 1'b1; else io_rd_i = 1'b1;
    base = alt_base_i ? 8'hE8 : 8'hF0;
    off  = addr - base;
    hit  = (off < 8'd6);
    if (hit && is_wr && off == 8'd5) m_bank = data[0];
    if (hit && is_wr && off == 8'd4 && data[0]) m_armed = 1'b0;
    e = idle_exp();
    if (hit) begin
      if (is_wr) begin
        if (off < 8'd3) e.cwr[off[1:0]] = 1'b1;
        if (off == 8'd3) e.mwr = 1'b1;
        if (off == 8'd4) e.cw = 1'b1;
      end else begin
        if (off < 8'd3) e.crd[off[1:0]] = 1'b1;
        if (off == 8'd4) e.srd = 1'b1;
        if (off == 8'd3 || off == 8'd5) begin e.urd = 1'b1; e.rdat = 8'hFF; end
      end
    end
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;   // strobe still held: no second pulse
    exp_q.push_back(idle_exp()); tag_q.push_back({tag, " hold R5"});
    @(negedge clk);
    io_wr_i = 1'b0; io_rd_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_bank = 1'b0; m_armed = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_now(input string tag);
    obs_t a, e;
    @(negedge clk);
    a = sample(); e = idle_exp();
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog R5: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check_now("R7 reset force=F bank=0");
    // Default group, channel data ports.
    for (int k = 0; k < 3; k++) begin
      access(1'b1, 8'hF0 + 8'(k), 8'h5A, "R1 chan write");
      access(1'b0, 8'hF0 + 8'(k), 8'h00, "R1 chan read");
    end
    access(1'b1, 8'hF3, 8'h36, "R3 mode write");
    access(1'b0, 8'hF3, 8'h00, "R10 unused read off3");
    access(1'b0, 8'hF4, 8'h00, "R3 status read");
    access(1'b1, 8'hF4, 8'hFE, "R8 ctl write bit0=0 keeps force");
    access(1'b1, 8'hF5, 8'h01, "R6 bank set");
    access(1'b0, 8'hF5, 8'h00, "R10 unused read off5");
    access(1'b1, 8'hF6, 8'h00, "R4 above group");
    access(1'b1, 8'hEF, 8'h00, "R4 below group");
    access(1'b1, 8'hE8, 8'h00, "R2 alt port while default");
    access(1'b1, 8'hF4, 8'h01, "R8 release");
    access(1'b1, 8'hF4, 8'h00, "R9 no rearm");
    access(1'b1, 8'hF5, 8'h00, "R6 bank clear");
    // Alternate group.
    alt_base_i = 1'b1;
    @(negedge clk);
    access(1'b1, 8'hE8, 8'h11, "R2 chan0 write");
    access(1'b0, 8'hEA, 8'h00, "R2 chan2 read");
    access(1'b1, 8'hEB, 8'h00, "R2 mode write");
    access(1'b1, 8'hED, 8'h01, "R2 bank via alt");
    access(1'b1, 8'hF5, 8'h00, "R2 default port ignored");
    access(1'b1, 8'hEE, 8'h00, "R4 above alt group");
    access(1'b1, 8'hE7, 8'h00, "R4 below alt group");
    access(1'b0, 8'hED, 8'h00, "R10 alt unused read");
    do_reset();
    check_now("R9 reset rearms, R6 bank cleared");
    access(1'b1, 8'hEC, 8'h01, "R8 alt release");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule